// File: doc/BRIEF.md
# Lock-Gated Boot-Loaded Configuration Register

This block holds one 32-bit configuration word that feeds timer and clock-control logic elsewhere on the chip. Before software runs, a loader presents the word read from nonvolatile storage on a boot strobe. The word comes with a fail flag and a blank flag. The register captures the word only when both flags are clear. When either flag is set, the register keeps its reset contents.

After boot, software can update the register through a small write port. The write port has an address, data and byte-enables. A 2-bit lock code decides which bits a write may change:

- With the code at 2'b00, every implemented bit is open to writes.
- With the code at 2'b10, only the two-bit clock-select field at bits 11:10 stays open.
- With the two remaining codes, the register is frozen against writes.

Writes to locked bits are dropped without any error indication. Bit 6 is not implemented and always reads as zero.

The write port is a valid/ready interface:

- `wr_ready` drops in any cycle where `boot_valid` is high, because the boot load takes priority.
- A master that sees `wr_ready` low must hold its write unchanged until a cycle where `wr_ready` is high.
- A write is accepted in a cycle with both `wr_valid` and `wr_ready` high. It takes effect only when `wr_addr` matches the register's offset, 0x20.

The boot strobe and the lock code are plain control inputs with no handshake.

Top module: `cfg_lockreg`

## Requirements
- R1: After reset, `cfg_q` equals 0x7F7FFF38.
- R2: A cycle with `boot_valid`=1, `boot_fail`=0 and `boot_blank`=0 loads `boot_data` into `cfg_q` at the next clock edge, with bit 6 forced to 0.
- R3: A cycle with `boot_valid`=1 and either `boot_fail`=1 or `boot_blank`=1 leaves `cfg_q` unchanged.
- R4: With `lock_code`=2'b00, an accepted write to offset 0x20 replaces every implemented bit of each byte whose enable is set, visible on `cfg_q` after the next clock edge.
- R5: With `lock_code`=2'b10, an accepted write changes only bits 11:10, and only when `wr_be[1]` is set. All other bits keep their values.
- R6: With `lock_code`=2'b01 or 2'b11, an accepted write leaves `cfg_q` unchanged.
- R7: Byte i of the register (bits 8i+7:8i) is never changed by a write with `wr_be[i]`=0.
- R8: `wr_ready` is 0 in every cycle with `boot_valid`=1 and 1 otherwise. A write held across such a cycle is applied once `wr_ready` returns to 1.
- R9: An accepted write whose `wr_addr` differs from 0x20 leaves `cfg_q` unchanged.
- R10: Bit 6 of `cfg_q` reads 0 at all times, whatever is loaded or written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| boot_valid | input | 1 | Boot-load strobe, one cycle per word |
| boot_data | input | 32 | Configuration word from storage |
| boot_fail | input | 1 | Storage read reported an error |
| boot_blank | input | 1 | Storage word is blank or erased |
| lock_code | input | 2 | Write lock code |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request accepted this cycle |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Write byte-enables, bit i covers bits 8i+7:8i |
| cfg_q | output | 32 | Current register value |

## Verification
The bench builds the block with its default parameters. These are a 32-bit register with four byte lanes, an 8-bit offset matched against 0x20, reset value 0x7F7FFF38, bit 6 unimplemented and bits 11:10 as the field that stays open under code 2'b10.

With these values, one short sequence reaches every combination the block distinguishes:

- good, failed, blank and doubly bad boot words;
- writes under all four lock codes;
- partial byte-enable masks that cut across the open field;
- a write to a wrong offset;
- writes collided with a boot strobe.

// File: rtl/cfg_lockreg_pkg.sv
package cfg_lockreg_pkg;
  typedef enum logic [1:0] {
    LOCK_OPEN   = 2'b00,
    LOCK_SHUT_A = 2'b01,
    LOCK_CLKSEL = 2'b10,
    LOCK_SHUT_B = 2'b11
  } lock_e;
endpackage

// File: rtl/cfg_lockreg_perm.sv
module cfg_lockreg_perm
  import cfg_lockreg_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL_MASK = 32'hFFFF_FFBF,
  parameter logic [WIDTH-1:0] WIDE_MASK = 32'h0000_0C00,
  localparam int NBYTES = WIDTH / 8
) (
  input  logic [1:0]        lock_code,
  input  logic [NBYTES-1:0] be,
  output logic [WIDTH-1:0]  wr_mask
);
  lock_e              lk;
  logic [WIDTH-1:0]   lock_mask;

  assign lk = lock_e'(lock_code);

  always_comb begin
    case (lk)
      LOCK_OPEN:   lock_mask = IMPL_MASK;
      LOCK_CLKSEL: lock_mask = WIDE_MASK & IMPL_MASK;
      default:     lock_mask = '0;
    endcase
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign wr_mask[i*8 +: 8] = {8{be[i]}} & lock_mask[i*8 +: 8];
  end
endmodule

// File: rtl/cfg_lockreg_boot.sv
module cfg_lockreg_boot #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] IMPL_MASK = 32'hFFFF_FFBF
) (
  input  logic             boot_valid,
  input  logic [WIDTH-1:0] boot_data,
  input  logic             boot_fail,
  input  logic             boot_blank,
  output logic             load,
  output logic [WIDTH-1:0] load_data
);
  logic trusted;

  assign trusted   = !boot_fail && !boot_blank;
  assign load      = boot_valid && trusted;
  assign load_data = boot_data & IMPL_MASK;
endmodule

// File: rtl/cfg_lockreg.sv
module cfg_lockreg #(
  parameter int WIDTH = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h20,
  parameter logic [WIDTH-1:0] RESET_VAL = 32'h7F7F_FF38,
  parameter logic [WIDTH-1:0] IMPL_MASK = 32'hFFFF_FFBF,
  parameter logic [WIDTH-1:0] WIDE_MASK = 32'h0000_0C00,
  localparam int NBYTES = WIDTH / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_valid,
  input  logic [WIDTH-1:0]  boot_data,
  input  logic              boot_fail,
  input  logic              boot_blank,
  input  logic [1:0]        lock_code,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [NBYTES-1:0] wr_be,
  output logic [WIDTH-1:0]  cfg_q
);
  logic             load;
  logic [WIDTH-1:0] load_data;
  logic [WIDTH-1:0] wr_mask;
  logic             wr_hit;
  logic [WIDTH-1:0] q_r, q_next;

  cfg_lockreg_boot #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK)) u_boot (
    .boot_valid(boot_valid), .boot_data(boot_data),
    .boot_fail(boot_fail), .boot_blank(boot_blank),
    .load(load), .load_data(load_data)
  );

  cfg_lockreg_perm #(.WIDTH(WIDTH), .IMPL_MASK(IMPL_MASK), .WIDE_MASK(WIDE_MASK)) u_perm (
    .lock_code(lock_code), .be(wr_be), .wr_mask(wr_mask)
  );

  assign wr_ready = !boot_valid;
  assign wr_hit   = wr_valid && wr_ready && (wr_addr == REG_OFFSET);

  always_comb begin
    q_next = q_r;
    if (load)
      q_next = load_data;
    else if (wr_hit)
      q_next = (q_r & ~wr_mask) | (wr_data & wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= RESET_VAL & IMPL_MASK;
    else        q_r <= q_next;
  end

  assign cfg_q = q_r;

  AST_GOOD_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_valid && !boot_fail && !boot_blank) |=> cfg_q == ($past(boot_data) & IMPL_MASK)); // R2
  AST_BAD_BOOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_valid && (boot_fail || boot_blank)) |=> $stable(cfg_q)); // R3
  AST_SHUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_valid && lock_code[0]) |=> $stable(cfg_q)); // R6
  AST_CLKSEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_valid && lock_code == 2'b10) |=> ((cfg_q & ~WIDE_MASK) == ($past(cfg_q) & ~WIDE_MASK))); // R5
  AST_BOOT_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    boot_valid |-> !wr_ready); // R8
  AST_OFFSET_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (!boot_valid && wr_addr != REG_OFFSET) |=> $stable(cfg_q)); // R9
  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & ~IMPL_MASK) == '0); // R10
endmodule

// File: tb/cfg_lockreg_tb.sv
module cfg_lockreg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        boot_valid = 1'b0;
  logic [31:0] boot_data = '0;
  logic        boot_fail = 1'b0;
  logic        boot_blank = 1'b0;
  logic [1:0]  lock_code = 2'b00;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = 8'h20;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [31:0] cfg_q;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] ref_q;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_lockreg u_dut (
    .clk(clk), .rst_n(rst_n), .boot_valid(boot_valid), .boot_data(boot_data),
    .boot_fail(boot_fail), .boot_blank(boot_blank), .lock_code(lock_code),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .cfg_q(cfg_q)
  );

  // Behavioural reference model, written from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= 32'h7F7F_FF38;
    else if (boot_valid) begin
      if (!boot_fail && !boot_blank) ref_q <= boot_data & ~(32'h1 << 6);
    end else if (wr_valid && wr_addr == 8'h20) begin
      logic [31:0] t;
      t = ref_q;
      for (int b = 0; b < 32; b++) begin
        bit open;
        open = (lock_code == 2'b00 && b != 6) ||
               (lock_code == 2'b10 && (b == 10 || b == 11));
        if (wr_be[b/8] && open) t[b] = wr_data[b];
      end
      ref_q <= t;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) if (rst_n) chk({cur_req, " model"}, cfg_q, ref_q);

  task automatic step(input logic bv, input logic [31:0] bd, input logic bf, input logic bb,
                      input logic wv, input logic [7:0] wa, input logic [31:0] wd,
                      input logic [3:0] be, input logic [1:0] lk);
    boot_valid = bv; boot_data = bd; boot_fail = bf; boot_blank = bb;
    wr_valid = wv; wr_addr = wa; wr_data = wd; wr_be = be; lock_code = lk;
    #1;
    chk("R8 ready", {31'd0, wr_ready}, {31'd0, !bv});
    @(posedge clk);
    @(negedge clk);
    #1;
    boot_valid = 1'b0; wr_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (2000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    repeat (2) @(negedge clk);
    chk("R1", cfg_q, 32'h7F7F_FF38);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", cfg_q, 32'h7F7F_FF38);

    cur_req = "R2";
    step(1, 32'h1234_5678, 0, 0, 0, 8'h20, 0, 4'h0, 2'b00);
    chk("R2", cfg_q, 32'h1234_5638);
    chk("R10", cfg_q & 32'h40, 32'h0);

    cur_req = "R3";
    step(1, 32'hFFFF_FFFF, 1, 0, 0, 8'h20, 0, 4'h0, 2'b00);
    chk("R3 fail", cfg_q, 32'h1234_5638);
    step(1, 32'h0000_0000, 0, 1, 0, 8'h20, 0, 4'h0, 2'b00);
    chk("R3 blank", cfg_q, 32'h1234_5638);
    step(1, 32'hDEAD_BEEF, 1, 1, 0, 8'h20, 0, 4'h0, 2'b00);
    chk("R3 both", cfg_q, 32'h1234_5638);

    cur_req = "R4";
    step(0, 0, 0, 0, 1, 8'h20, 32'hA5A5_A5FF, 4'hF, 2'b00);
    chk("R4", cfg_q, 32'hA5A5_A5BF);
    chk("R10", cfg_q & 32'h40, 32'h0);

    cur_req = "R7";
    step(0, 0, 0, 0, 1, 8'h20, 32'h0, 4'b0101, 2'b00);
    chk("R7", cfg_q, 32'hA500_A500);

    cur_req = "R5";
    step(0, 0, 0, 0, 1, 8'h20, 32'hFFFF_FFFF, 4'hF, 2'b10);
    chk("R5 set", cfg_q, 32'hA500_AD00);
    step(0, 0, 0, 0, 1, 8'h20, 32'h0, 4'b1101, 2'b10);
    chk("R5 R7 lane off", cfg_q, 32'hA500_AD00);
    step(0, 0, 0, 0, 1, 8'h20, 32'h0, 4'b0010, 2'b10);
    chk("R5 clear", cfg_q, 32'hA500_A100);

    cur_req = "R6";
    step(0, 0, 0, 0, 1, 8'h20, 32'hFFFF_FFFF, 4'hF, 2'b01);
    chk("R6 code01", cfg_q, 32'hA500_A100);
    step(0, 0, 0, 0, 1, 8'h20, 32'h0, 4'hF, 2'b11);
    chk("R6 code11", cfg_q, 32'hA500_A100);

    cur_req = "R9";
    step(0, 0, 0, 0, 1, 8'h24, 32'hFFFF_FFFF, 4'hF, 2'b00);
    chk("R9", cfg_q, 32'hA500_A100);

    cur_req = "R8";
    step(1, 32'h0F0F_0F0F, 0, 0, 1, 8'h20, 32'h1111_1111, 4'hF, 2'b00);
    chk("R8 boot wins", cfg_q, 32'h0F0F_0F0F);
    step(0, 0, 0, 0, 1, 8'h20, 32'h1111_1111, 4'hF, 2'b00);
    chk("R8 held write", cfg_q, 32'h1111_1111);
    step(1, 32'hFFFF_FFFF, 1, 0, 1, 8'h20, 32'h2222_2222, 4'hF, 2'b00);
    chk("R8 R3 bad boot blocks", cfg_q, 32'h1111_1111);

    cur_req = "R10";
    step(1, 32'hFFFF_FFFF, 0, 0, 0, 8'h20, 0, 4'h0, 2'b00);
    chk("R10", cfg_q, 32'hFFFF_FFBF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule